// File: doc/BRIEF.md
# Packet Line Buffer Handshake Controller

This block owns a single line buffer that a processor shares with a packet router. It has two engines. The receive engine, once the processor arms it, writes an incoming stream of 32-bit lines into the buffer from line 0 upward. When the packet ends it reports success together with the number of lines it took, or a fault if the packet was flagged bad or did not fit. The transmit engine is given a line count and streams that many lines, from line 0 upward, out of the buffer on a valid/ready interface.

The processor drives both engines through one control word. That word has separate arm and reset bits for each engine and carries the transmit length in its upper half. The processor polls a status word that shows, for each engine, whether it is idle, finished or faulted. A processor-side port gives direct access to the buffer, so the processor can read a received packet or fill the buffer before a transmit. The intended flow on the receive side is: reset the engine, wait for idle, then arm it. On the transmit side the flow is: wait for the engine to finish, reset it, fill the buffer while it is idle, then start it.

Top module: `pktbuf_hs_ctrl`

## Requirements
- R1: After reset the status word reads 0x0000_0044, which means both engines are idle and every other bit is 0. In this state rx_ready and tx_valid are low.
- R2: A control write with bit 1 set arms the receive engine, but only if that engine is idle. While it is armed, rx_ready is high and each accepted line is stored at the next buffer index, starting from index 0.
- R3: An accepted line with rx_last set and rx_err clear moves the receive engine to finished. Status bit 0 then reads 1 and status bits 31:16 hold the number of lines accepted. Those bits read 0 in every other receive state.
- R4: The receive engine moves to fault (status bit 1) in two cases: when a line carrying both rx_last and rx_err is accepted, and when a line arrives after the buffer already holds DEPTH lines. That extra line is not stored. In the fault state rx_ready is low.
- R5: Control bit 0 returns the receive engine to idle (status bit 2), and control bit 2 does the same for the transmit engine (status bit 6). Either reset works from any state. A reset set in the same write as its engine's start bit wins over the start. A start is ignored unless its engine is idle.
- R6: A control write with bit 3 set and a count N in bits 31:16, where 1 ≤ N ≤ DEPTH, makes the transmit engine present buffer lines 0 to N−1 in order on tx_data. tx_last is raised only on line N−1. Each line stays presented while tx_ready is low. After line N−1 is accepted the engine is finished (status bit 4).
- R7: A transmit start with N = 0 finishes at once without raising tx_valid. A transmit start with N > DEPTH faults at once (status bit 5) without raising tx_valid.
- R8: cpu_buf_rdata always shows the buffer line at cpu_buf_addr. A processor buffer write is ignored while the receive engine is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word: bit 0 receive reset, bit 1 receive arm, bit 2 transmit reset, bit 3 transmit start, bits 31:16 transmit count |
| status | output | 32 | Status word: bits 0/1/2 receive finished/fault/idle, bits 4/5/6 transmit finished/fault/idle, bits 31:16 received line count |
| cpu_buf_we | input | 1 | Processor buffer write strobe |
| cpu_buf_addr | input | $clog2(DEPTH) | Processor buffer line index |
| cpu_buf_wdata | input | DW | Processor buffer write data |
| cpu_buf_rdata | output | DW | Buffer line at cpu_buf_addr |
| rx_data | input | DW | Incoming line |
| rx_valid | input | 1 | Incoming line valid |
| rx_last | input | 1 | Incoming line ends the packet |
| rx_err | input | 1 | Source marks the packet bad (qualified by rx_last) |
| rx_ready | output | 1 | Receive engine accepts a line |
| tx_data | output | DW | Outgoing line |
| tx_valid | output | 1 | Outgoing line valid |
| tx_last | output | 1 | Outgoing line is the final one |
| tx_ready | input | 1 | Sink accepts the outgoing line |

## Verification
The bench builds the block with DEPTH = 8 and DW = 32. The small depth brings the overflow fault, the exact-fit packet of DEPTH lines and the transmit count just above DEPTH within a few dozen cycles. The transmit tests drive tx_ready with a stall pattern, so both the hold of a line under backpressure and the placement of tx_last get exercised.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

  typedef enum logic [1:0] {RX_IDLE, RX_ARMED, RX_DONE, RX_FAULT} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_DONE, TX_FAULT} tx_state_e;

  localparam int LEN_LSB = 16;
  localparam int LEN_W   = 16;

  typedef struct packed {
    logic             rx_clr;
    logic             rx_go;
    logic             tx_clr;
    logic             tx_go;
    logic [LEN_W-1:0] tx_len;
  } ctrl_cmd_t;

  // Control word decode; a strobe of 0 yields no commands.
  function automatic ctrl_cmd_t decode_ctrl(input logic [31:0] w, input logic en);
    ctrl_cmd_t c;
    c.rx_clr = en & w[0];
    c.rx_go  = en & w[1];
    c.tx_clr = en & w[2];
    c.tx_go  = en & w[3];
    c.tx_len = w[LEN_LSB +: LEN_W];
    return c;
  endfunction

  // Status word assembly; count only visible when receive has finished.
  function automatic logic [31:0] pack_status(input rx_state_e r, input tx_state_e t,
                                              input logic [LEN_W-1:0] cnt);
    logic [31:0] s;
    s = '0;
    s[0] = (r == RX_DONE);
    s[1] = (r == RX_FAULT);
    s[2] = (r == RX_IDLE);
    s[4] = (t == TX_DONE);
    s[5] = (t == TX_FAULT);
    s[6] = (t == TX_IDLE);
    s[LEN_LSB +: LEN_W] = (r == RX_DONE) ? cnt : '0;
    return s;
  endfunction

  // Transmit length classification.
  function automatic logic len_fits(input logic [LEN_W-1:0] len, input int unsigned depth);
    return (32'(len) <= depth);
  endfunction

endpackage

// File: rtl/pktbuf_line_ram.sv
module pktbuf_line_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/pktbuf_rx_engine.sv
module pktbuf_rx_engine
  import pktbuf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_clr,
  input  logic          cmd_go,
  input  logic [DW-1:0] s_data,
  input  logic          s_valid,
  input  logic          s_last,
  input  logic          s_err,
  output logic          s_ready,
  output rx_state_e     state,
  output logic [CW-1:0] line_cnt,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic ev_fire, ev_full, ev_overflow, ev_start_ok;

  assign s_ready     = (state == RX_ARMED);
  assign ev_fire     = s_valid && s_ready;
  assign ev_full     = (line_cnt == FULL_CNT);
  assign ev_overflow = ev_fire && ev_full;
  assign ev_start_ok = cmd_go && !cmd_clr && (state == RX_IDLE);

  assign wr_en   = ev_fire && !ev_full && !cmd_clr;
  assign wr_addr = line_cnt[AW-1:0];
  assign wr_data = s_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      line_cnt <= '0;
    end else if (cmd_clr) begin
      state    <= RX_IDLE;
      line_cnt <= '0;
    end else begin
      case (state)
        RX_IDLE: if (ev_start_ok) begin
          state    <= RX_ARMED;
          line_cnt <= '0;
        end
        RX_ARMED: if (ev_overflow) begin
          state <= RX_FAULT;
        end else if (ev_fire) begin
          line_cnt <= line_cnt + 1'b1;
          if (s_last) state <= s_err ? RX_FAULT : RX_DONE;
        end
        default: ;
      endcase
    end
  end

  // R5: a reset always lands in idle
  a_r5_rx_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> state == RX_IDLE);

  // R5: start outside idle is ignored
  a_r5_rx_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !cmd_clr && (state == RX_DONE || state == RX_FAULT)) |=> state == $past(state));

  // R4: a line beyond the buffer depth faults the engine
  a_r4_overflow_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_overflow && !cmd_clr) |=> state == RX_FAULT);

  // R4: the count never exceeds the buffer depth
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt <= FULL_CNT);

  // R2: an armed engine leaves armed only via a line or a reset
  a_r2_armed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_ARMED && !s_valid && !cmd_clr) |=> state == RX_ARMED);

endmodule

// File: rtl/pktbuf_tx_engine.sv
module pktbuf_tx_engine
  import pktbuf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_clr,
  input  logic             cmd_go,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [DW-1:0]    rd_data,
  output logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    m_data,
  output logic             m_valid,
  output logic             m_last,
  input  logic             m_ready,
  output tx_state_e        state
);

  logic [AW-1:0] ptr, last_idx;
  logic ev_start_ok, ev_fire, ev_len_zero, ev_len_fits;

  assign ev_start_ok = cmd_go && !cmd_clr && (state == TX_IDLE);
  assign ev_len_zero = (cmd_len == '0);
  assign ev_len_fits = len_fits(cmd_len, DEPTH);
  assign m_valid     = (state == TX_SEND);
  assign m_last      = m_valid && (ptr == last_idx);
  assign m_data      = rd_data;
  assign rd_addr     = ptr;
  assign ev_fire     = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      ptr      <= '0;
      last_idx <= '0;
    end else if (cmd_clr) begin
      state <= TX_IDLE;
      ptr   <= '0;
    end else begin
      case (state)
        TX_IDLE: if (ev_start_ok) begin
          ptr <= '0;
          if (ev_len_zero) begin
            state <= TX_DONE;
          end else if (!ev_len_fits) begin
            state <= TX_FAULT;
          end else begin
            state    <= TX_SEND;
            last_idx <= AW'(cmd_len - 1'b1);
          end
        end
        TX_SEND: if (ev_fire) begin
          if (ptr == last_idx) state <= TX_DONE;
          else ptr <= ptr + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R5: a reset always lands in idle
  a_r5_tx_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> state == TX_IDLE);

  // R6: a stalled line stays presented at the same index
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !cmd_clr) |=> (m_valid && $stable(rd_addr)));

  // R6: accepting the final line finishes the engine
  a_r6_last_finishes: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && m_last && !cmd_clr) |=> state == TX_DONE);

  // R7: a zero count finishes without presenting a line
  a_r7_zero_len_done: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start_ok && ev_len_zero) |=> (state == TX_DONE && !m_valid));

  // R7: an oversize count faults without presenting a line
  a_r7_oversize_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start_ok && !ev_len_fits) |=> (state == TX_FAULT && !m_valid));

endmodule

// File: rtl/pktbuf_hs_ctrl.sv
module pktbuf_hs_ctrl
  import pktbuf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctrl_we,
  input  logic [31:0]              ctrl_wdata,
  output logic [31:0]              status,
  input  logic                     cpu_buf_we,
  input  logic [$clog2(DEPTH)-1:0] cpu_buf_addr,
  input  logic [DW-1:0]            cpu_buf_wdata,
  output logic [DW-1:0]            cpu_buf_rdata,
  input  logic [DW-1:0]            rx_data,
  input  logic                     rx_valid,
  input  logic                     rx_last,
  input  logic                     rx_err,
  output logic                     rx_ready,
  output logic [DW-1:0]            tx_data,
  output logic                     tx_valid,
  output logic                     tx_last,
  input  logic                     tx_ready
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  ctrl_cmd_t     cmd;
  rx_state_e     rx_st;
  tx_state_e     tx_st;
  logic [CW-1:0] rx_cnt;
  logic          rx_we, ram_we, cpu_wr_ok;
  logic [AW-1:0] rx_waddr, ram_waddr, tx_raddr;
  logic [DW-1:0] rx_wdata, ram_wdata, tx_rdata;

  assign cmd = decode_ctrl(ctrl_wdata, ctrl_we);

  pktbuf_rx_engine #(.DW(DW), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .cmd_clr(cmd.rx_clr), .cmd_go(cmd.rx_go),
    .s_data(rx_data), .s_valid(rx_valid), .s_last(rx_last), .s_err(rx_err),
    .s_ready(rx_ready), .state(rx_st), .line_cnt(rx_cnt),
    .wr_en(rx_we), .wr_addr(rx_waddr), .wr_data(rx_wdata)
  );

  pktbuf_tx_engine #(.DW(DW), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .cmd_clr(cmd.tx_clr), .cmd_go(cmd.tx_go),
    .cmd_len(cmd.tx_len), .rd_data(tx_rdata), .rd_addr(tx_raddr),
    .m_data(tx_data), .m_valid(tx_valid), .m_last(tx_last), .m_ready(tx_ready),
    .state(tx_st)
  );

  // Processor writes are locked out while the receive engine owns the buffer.
  assign cpu_wr_ok = cpu_buf_we && (rx_st != RX_ARMED);
  assign ram_we    = rx_we || cpu_wr_ok;
  assign ram_waddr = rx_we ? rx_waddr : cpu_buf_addr;
  assign ram_wdata = rx_we ? rx_wdata : cpu_buf_wdata;

  pktbuf_line_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr_a(tx_raddr), .rdata_a(tx_rdata),
    .raddr_b(cpu_buf_addr), .rdata_b(cpu_buf_rdata)
  );

  assign status = pack_status(rx_st, tx_st, LEN_W'(rx_cnt));

  // R1: at most one receive and one transmit condition is reported
  a_r1_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[2:0]) && $onehot0(status[6:4]));

  // R3: a finished receive always reports at least one line
  a_r3_done_has_lines: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> status[31:16] != 16'd0);

  // R8: no processor write reaches the buffer while receive is armed
  a_r8_cpu_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_buf_we && rx_ready && !rx_valid) |-> !ram_we);

endmodule

// File: tb/pktbuf_hs_ctrl_tb_top.sv
module pktbuf_hs_ctrl_tb_top;

  localparam int DW    = 32;
  localparam int DEPTH = 8;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_we = 1'b0;
  logic [31:0]   ctrl_wdata = '0;
  logic [31:0]   status;
  logic          cpu_buf_we = 1'b0;
  logic [AW-1:0] cpu_buf_addr = '0;
  logic [DW-1:0] cpu_buf_wdata = '0;
  logic [DW-1:0] cpu_buf_rdata;
  logic [DW-1:0] rx_data = '0;
  logic          rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic          rx_ready;
  logic [DW-1:0] tx_data;
  logic          tx_valid, tx_last;
  logic          tx_ready = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pktbuf_hs_ctrl #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .status(status), .cpu_buf_we(cpu_buf_we), .cpu_buf_addr(cpu_buf_addr),
    .cpu_buf_wdata(cpu_buf_wdata), .cpu_buf_rdata(cpu_buf_rdata),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last), .rx_err(rx_err),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_ready(tx_ready)
  );

  // Expected status word, built from the bit positions in the requirements.
  function automatic logic [31:0] exp_stat(input bit rdone, rfault, ridle,
                                           input bit tdone, tfault, tidle,
                                           input int cnt);
    return {16'(cnt), 9'd0, tidle, tfault, tdone, 1'b0, ridle, rfault, rdone};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr_ctrl(input logic [31:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic rx_push(input logic [31:0] d, input bit last, input bit err);
    rx_valid = 1'b1; rx_data = d; rx_last = last; rx_err = err;
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  task automatic cpu_write(input int a, input logic [31:0] d);
    cpu_buf_we = 1'b1; cpu_buf_addr = AW'(a); cpu_buf_wdata = d;
    @(negedge clk);
    cpu_buf_we = 1'b0;
  endtask

  task automatic cpu_read_chk(input string req, input int a, input logic [31:0] exp);
    cpu_buf_addr = AW'(a);
    #1;
    chk(req, "buffer line", cpu_buf_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1", "status after reset", status, 32'h0000_0044);
    chk("R1", "rx_ready after reset", 32'(rx_ready), 0);
    chk("R1", "tx_valid after reset", 32'(tx_valid), 0);
  endtask

  task automatic t_rx_basic;
    wr_ctrl(32'h2);
    chk("R2", "status armed", status, exp_stat(0,0,0,0,0,1,0));
    chk("R2", "rx_ready armed", 32'(rx_ready), 1);
    rx_push(32'h11, 0, 0);
    rx_push(32'h22, 0, 0);
    chk("R3", "count hidden while armed", status, exp_stat(0,0,0,0,0,1,0));
    rx_push(32'h33, 1, 0);
    chk("R3", "status finished", status, exp_stat(1,0,0,0,0,1,3));
    chk("R3", "rx_ready after finish", 32'(rx_ready), 0);
    cpu_read_chk("R2", 0, 32'h11);
    cpu_read_chk("R2", 1, 32'h22);
    cpu_read_chk("R8", 2, 32'h33);
  endtask

  task automatic t_rx_start_rules;
    wr_ctrl(32'h2);
    chk("R5", "rx start ignored when finished", status, exp_stat(1,0,0,0,0,1,3));
    wr_ctrl(32'h3);
    chk("R5", "rx reset beats start", status, exp_stat(0,0,1,0,0,1,0));
    chk("R5", "rx_ready after reset", 32'(rx_ready), 0);
  endtask

  task automatic t_rx_err;
    wr_ctrl(32'h2);
    rx_push(32'h44, 0, 0);
    rx_push(32'h55, 1, 1);
    chk("R4", "source error faults", status, exp_stat(0,1,0,0,0,1,0));
    wr_ctrl(32'h2);
    chk("R5", "rx start ignored in fault", status, exp_stat(0,1,0,0,0,1,0));
    wr_ctrl(32'h1);
    chk("R5", "rx reset from fault", status, exp_stat(0,0,1,0,0,1,0));
    wr_ctrl(32'h2);
    rx_push(32'h66, 1, 0);
    chk("R3", "re-armed single line", status, exp_stat(1,0,0,0,0,1,1));
    cpu_read_chk("R2", 0, 32'h66);
    wr_ctrl(32'h1);
  endtask

  task automatic t_rx_overflow;
    wr_ctrl(32'h2);
    for (int i = 0; i < DEPTH; i++) rx_push(32'h100 + i, 0, 0);
    chk("R4", "still armed when full", status, exp_stat(0,0,0,0,0,1,0));
    chk("R4", "ready when full", 32'(rx_ready), 1);
    rx_push(32'hDEAD, 0, 0);
    chk("R4", "overflow faults", status, exp_stat(0,1,0,0,0,1,0));
    chk("R4", "rx_ready in fault", 32'(rx_ready), 0);
    cpu_read_chk("R4", 0, 32'h100);
    cpu_read_chk("R4", DEPTH - 1, 32'h100 + DEPTH - 1);
    wr_ctrl(32'h1);
    wr_ctrl(32'h2);
    for (int i = 0; i < DEPTH; i++) rx_push(32'h200 + i, i == DEPTH - 1, 0);
    chk("R3", "exact depth packet", status, exp_stat(1,0,0,0,0,1,DEPTH));
    wr_ctrl(32'h1);
  endtask

  task automatic t_cpu_lock;
    wr_ctrl(32'h2);
    cpu_write(0, 32'hBAD0_BAD0);
    cpu_read_chk("R8", 0, 32'h200);
    wr_ctrl(32'h1);
    cpu_write(0, 32'hC0DE_0000);
    cpu_read_chk("R8", 0, 32'hC0DE_0000);
  endtask

  task automatic tx_collect(input int n, input logic [31:0] base, input logic [7:0] pat);
    int got = 0;
    int guard = 0;
    while (got < n && guard < 100) begin
      tx_ready = pat[guard % 8];
      #1;
      if (tx_valid && tx_ready) begin
        chk("R6", "tx line data", tx_data, base + 32'(got));
        chk("R6", "tx_last placement", 32'(tx_last), 32'(got == n - 1));
        got++;
      end else if (tx_valid) begin
        chk("R6", "stalled line data", tx_data, base + 32'(got));
      end
      guard++;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk("R6", "tx lines delivered", 32'(got), 32'(n));
  endtask

  task automatic t_tx_stream;
    for (int i = 0; i < 5; i++) cpu_write(i, 32'hA000_0000 + i);
    wr_ctrl((32'd5 << 16) | 32'h8);
    chk("R6", "status while sending", status, exp_stat(0,0,1,0,0,0,0));
    tx_collect(5, 32'hA000_0000, 8'b1011_0101);
    chk("R6", "tx finished", status, exp_stat(0,0,1,1,0,0,0));
    chk("R6", "tx_valid after finish", 32'(tx_valid), 0);
    wr_ctrl((32'd2 << 16) | 32'h8);
    chk("R5", "tx start ignored when finished", status, exp_stat(0,0,1,1,0,0,0));
    wr_ctrl(32'h4);
    chk("R5", "tx reset to idle", status, 32'h0000_0044);
    for (int i = 0; i < DEPTH; i++) cpu_write(i, 32'hB000_0000 + i);
    wr_ctrl((32'(DEPTH) << 16) | 32'h8);
    tx_collect(DEPTH, 32'hB000_0000, 8'hFF);
    chk("R6", "full-depth tx finished", status, exp_stat(0,0,1,1,0,0,0));
    wr_ctrl(32'h4);
  endtask

  task automatic t_tx_edges;
    wr_ctrl(32'h8);
    chk("R7", "zero count finishes", status, exp_stat(0,0,1,1,0,0,0));
    chk("R7", "zero count no valid", 32'(tx_valid), 0);
    wr_ctrl(32'h4);
    wr_ctrl((32'(DEPTH + 1) << 16) | 32'h8);
    chk("R7", "oversize count faults", status, exp_stat(0,0,1,0,1,0,0));
    chk("R7", "oversize no valid", 32'(tx_valid), 0);
    wr_ctrl(32'h4);
    wr_ctrl((32'd3 << 16) | 32'hC);
    chk("R5", "tx reset beats start", status, 32'h0000_0044);
    wr_ctrl((32'd3 << 16) | 32'h8);
    chk("R6", "tx presents first line", 32'(tx_valid), 1);
    wr_ctrl(32'h4);
    chk("R5", "tx reset aborts send", status, 32'h0000_0044);
    chk("R5", "tx_valid after abort", 32'(tx_valid), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_basic();
    t_rx_start_rules();
    t_rx_err();
    t_rx_overflow();
    t_cpu_lock();
    t_tx_stream();
    t_tx_edges();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule